// File: doc/BRIEF.md
# PLL Mode Control Register Block

This block is the processor-facing register pair that sets the operating mode of a clock generator's phase-locked loop. A simple synchronous 8-bit bus (address, write strobe, write data, registered read data) reaches two registers. The control register turns the loop on and routes the VCO clock to the base clock. The bandwidth register picks automatic or manual bandwidth handling, shows lock, and shows or sets acquisition versus tracking.

In automatic mode the loop's own lock and tracking status appear in the bandwidth register, and a write cannot change them. In manual mode software owns the tracking bit. That bit drives the acquisition/tracking control output. A hidden copy of the manual value survives a stay in automatic mode. A cross-register interlock keeps the VCO clock from being selected while the loop is off, and keeps the loop from being stopped while its clock is selected.

Top module: `pllm_regs`

## Requirements
- R1: On synchronous reset every stored bit clears. After reset `loop_on_o`, `vco_sel_o`, `track_ctl_o` and `rd_data` are 0, so the loop starts off, unselected, in manual mode and in acquisition.
- R2: `rd_data` is registered: it shows, one clock after `addr` is sampled, the contents at that address as of that edge. Any address other than 0x5C and 0x5D reads 0x00.
- R3: The control register is at 0x5C. Bit 5 is loop-on, driven on `loop_on_o`, and bit 4 is VCO select, driven on `vco_sel_o`. Bits 7:6 read 0 and bits 3:0 read 1, and writes to these bits are ignored.
- R4: A control write that clears loop-on is ignored for that bit while VCO select is 1 before the write. Such a write can still clear VCO select.
- R5: A control write sets VCO select only if loop-on is 1 both before and after that write. A single write that sets both bits from the off state therefore sets loop-on and leaves VCO select at 0. VCO select is never 1 while loop-on is 0.
- R6: The bandwidth register is at 0x5D. Bit 7 is the auto-mode bit (1 means automatic, 0 means manual, read/write). Bit 4 is a plain read/write flag. Bits 3:0 read 0.
- R7: Bit 6 of 0x5D reads `lock_in` while auto mode is 1, and reads 0 while auto mode is 0.
- R8: In manual mode, bit 5 of 0x5D reads the stored tracking value and is writable, where 1 means tracking and 0 means acquisition. `track_ctl_o` takes the value one clock after the write. In auto mode, bit 5 reads `track_in`, writes to it are ignored, and `track_ctl_o` equals `track_in` from the previous clock. Whether bit 5 is writable is judged by the auto bit before the write.
- R9: The stored manual tracking value is kept unchanged through auto mode. When auto mode clears, it again drives `track_ctl_o` and reads back at bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe, applied at the clock edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| lock_in | input | 1 | Loop lock status |
| track_in | input | 1 | Loop tracking status (1 = tracking) |
| loop_on_o | output | 1 | Loop enable |
| vco_sel_o | output | 1 | VCO clock selected as base clock |
| track_ctl_o | output | 1 | Acquisition/tracking control (1 = tracking) |

## Verification
A wrong interlock decision shows on `loop_on_o` or `vco_sel_o` one clock after the offending write. It stays there until a later write corrects it. A corrupted hidden manual tracking value cannot be seen while auto mode is set. It appears on `track_ctl_o` and on bit 5 of the read data one clock after auto mode clears, so the bench leaves auto mode with a value different from the one it last wrote. Mode-dependent read masking shows on the read data of the very next clock, so the reference model is compared with every port on every cycle.

// File: rtl/pllm_pkg.sv
package pllm_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned LOW_W = 4;
  // control register bit positions
  localparam int unsigned CTL_ON_BIT  = 5;
  localparam int unsigned CTL_SEL_BIT = 4;
  // bandwidth register bit positions
  localparam int unsigned BW_AUTO_BIT = 7;
  localparam int unsigned BW_LOCK_BIT = 6;
  localparam int unsigned BW_TRK_BIT  = 5;
  localparam int unsigned BW_AUX_BIT  = 4;

  typedef struct packed {
    logic loop_on;
    logic vco_sel;
  } ctl_state_t;

  typedef struct packed {
    logic auto_m;
    logic aux;
    logic trk_shadow;
  } bw_state_t;
endpackage

// File: rtl/pllm_ctrl_reg.sv
module pllm_ctrl_reg
  import pllm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic       on_req,
  input  logic       sel_req,
  output ctl_state_t state
);
  ctl_state_t q;
  logic on_nx;
  logic sel_nx;

  // loop-on cannot drop while the VCO clock is selected (judged pre-write)
  always_comb begin
    on_nx = q.loop_on;
    if (wr) begin
      if (on_req || !q.vco_sel) on_nx = on_req;
    end
  end

  // VCO select may rise only with the loop on before and after the write
  always_comb begin
    sel_nx = q.vco_sel;
    if (wr) begin
      if (!sel_req) sel_nx = 1'b0;
      else if (q.loop_on && on_nx) sel_nx = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q.loop_on <= on_nx;
      q.vco_sel <= sel_nx;
    end
  end

  assign state = q;
endmodule

// File: rtl/pllm_bw_reg.sv
module pllm_bw_reg
  import pllm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr,
  input  logic      auto_req,
  input  logic      trk_req,
  input  logic      aux_req,
  input  logic      track_in,
  output bw_state_t state,
  output logic      track_ctl_o
);
  bw_state_t q;
  logic auto_nx;
  logic aux_nx;
  logic shadow_nx;
  logic trk_out_q;

  always_comb begin
    auto_nx   = wr ? auto_req : q.auto_m;
    aux_nx    = wr ? aux_req : q.aux;
    // writable only while manual before this write; else held as shadow
    shadow_nx = (wr && !q.auto_m) ? trk_req : q.trk_shadow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q         <= '0;
      trk_out_q <= 1'b0;
    end else begin
      q.auto_m     <= auto_nx;
      q.aux        <= aux_nx;
      q.trk_shadow <= shadow_nx;
      trk_out_q    <= auto_nx ? track_in : shadow_nx;
    end
  end

  assign state       = q;
  assign track_ctl_o = trk_out_q;
endmodule

// File: rtl/pllm_rdmux.sv
module pllm_rdmux
  import pllm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h5C,
  parameter logic [ADDR_W-1:0] BW_ADDR  = 8'h5D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  ctl_state_t        ctl,
  input  bw_state_t         bw,
  input  logic              lock_in,
  input  logic              track_in,
  output logic [REG_W-1:0]  rd_data
);
  logic [REG_W-1:0] ctl_view;
  logic [REG_W-1:0] bw_view;
  logic [REG_W-1:0] sel_view;
  logic [REG_W-1:0] rd_q;

  // constant low nibbles: all ones in control, all zeros in bandwidth
  for (genvar b = 0; b < REG_W; b++) begin : g_bits
    if (b < LOW_W) begin : g_low
      assign ctl_view[b] = 1'b1;
      assign bw_view[b]  = 1'b0;
    end else if (b == CTL_ON_BIT) begin : g_on
      assign ctl_view[b] = ctl.loop_on;
      assign bw_view[b]  = bw.auto_m ? track_in : bw.trk_shadow;
    end else if (b == CTL_SEL_BIT) begin : g_sel
      assign ctl_view[b] = ctl.vco_sel;
      assign bw_view[b]  = bw.aux;
    end else if (b == BW_LOCK_BIT) begin : g_lock
      assign ctl_view[b] = 1'b0;
      assign bw_view[b]  = bw.auto_m & lock_in;
    end else begin : g_top
      assign ctl_view[b] = 1'b0;
      assign bw_view[b]  = bw.auto_m;
    end
  end

  always_comb begin
    if (addr == CTL_ADDR)     sel_view = ctl_view;
    else if (addr == BW_ADDR) sel_view = bw_view;
    else                      sel_view = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= sel_view;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/pllm_regs.sv
module pllm_regs
  import pllm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BW_ADDR = 8'h5D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              lock_in,
  input  logic              track_in,
  output logic              loop_on_o,
  output logic              vco_sel_o,
  output logic              track_ctl_o
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = BW_ADDR - 1'b1;

  ctl_state_t ctl_st;
  bw_state_t  bw_st;
  logic       ctl_wr;
  logic       bw_wr;
  logic       bw_auto;
  logic       unused_wbits;

  assign ctl_wr       = wr_en && (addr == CTL_ADDR);
  assign bw_wr        = wr_en && (addr == BW_ADDR);
  assign unused_wbits = ^{wr_data[LOW_W-1:0], wr_data[BW_LOCK_BIT]};

  pllm_ctrl_reg u_ctl (
    .clk     (clk),
    .rst     (rst),
    .wr      (ctl_wr),
    .on_req  (wr_data[CTL_ON_BIT]),
    .sel_req (wr_data[CTL_SEL_BIT]),
    .state   (ctl_st)
  );

  pllm_bw_reg u_bw (
    .clk         (clk),
    .rst         (rst),
    .wr          (bw_wr),
    .auto_req    (wr_data[BW_AUTO_BIT]),
    .trk_req     (wr_data[BW_TRK_BIT]),
    .aux_req     (wr_data[BW_AUX_BIT]),
    .track_in    (track_in),
    .state       (bw_st),
    .track_ctl_o (track_ctl_o)
  );

  pllm_rdmux #(
    .ADDR_W   (ADDR_W),
    .CTL_ADDR (CTL_ADDR),
    .BW_ADDR  (BW_ADDR)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .ctl      (ctl_st),
    .bw       (bw_st),
    .lock_in  (lock_in),
    .track_in (track_in),
    .rd_data  (rd_data)
  );

  assign loop_on_o = ctl_st.loop_on;
  assign vco_sel_o = ctl_st.vco_sel;
  assign bw_auto   = bw_st.auto_m;
endmodule

// File: rtl/pllm_regs_chk.sv
module pllm_regs_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BW_ADDR = 8'h5D
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rd_data,
  input logic              lock_in,
  input logic              track_in,
  input logic              loop_on_o,
  input logic              vco_sel_o,
  input logic              track_ctl_o,
  input logic              bw_auto
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = BW_ADDR - 1'b1;

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr != CTL_ADDR && addr != BW_ADDR) && !$past(rst)) |-> (rd_data == 8'h00));

  // R3
  ctl_fill_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr == CTL_ADDR) && !$past(rst)) |-> (rd_data[3:0] == 4'hF && rd_data[7:6] == 2'b00));

  // R4
  on_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(loop_on_o) |-> !$past(vco_sel_o));

  // R5
  sel_guard_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vco_sel_o) |-> $past(loop_on_o));

  // R5
  safe_pair_chk: assert property (@(posedge clk) disable iff (rst)
    vco_sel_o |-> loop_on_o);

  // R6
  bw_resv_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr == BW_ADDR) && !$past(rst)) |-> (rd_data[3:0] == 4'h0));

  // R7
  lock_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr == BW_ADDR) && !$past(rst) && !$past(bw_auto)) |-> !rd_data[6]);

  // R7
  lock_show_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr == BW_ADDR) && !$past(rst) && $past(bw_auto)) |-> (rd_data[6] == $past(lock_in)));

  // R8
  trk_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (bw_auto && !$past(rst)) |-> (track_ctl_o == $past(track_in)));
endmodule

bind pllm_regs pllm_regs_chk #(
  .ADDR_W  (ADDR_W),
  .BW_ADDR (BW_ADDR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .addr        (addr),
  .rd_data     (rd_data),
  .lock_in     (lock_in),
  .track_in    (track_in),
  .loop_on_o   (loop_on_o),
  .vco_sel_o   (vco_sel_o),
  .track_ctl_o (track_ctl_o),
  .bw_auto     (bw_auto)
);

// File: tb/sim_pllm_regs.sv
`timescale 1ns/1ps
module sim_pllm_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       lock_in = 1'b0;
  logic       track_in = 1'b0;
  logic       loop_on_o, vco_sel_o, track_ctl_o;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  bit       m_on, m_sel, m_auto, m_aux, m_shadow, m_trk;
  bit [7:0] m_rd;

  always #2 clk = ~clk;

  pllm_regs u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .lock_in(lock_in), .track_in(track_in),
    .loop_on_o(loop_on_o), .vco_sel_o(vco_sel_o), .track_ctl_o(track_ctl_o)
  );

  function automatic bit [7:0] model_view(input bit [7:0] a);
    if (a == 8'h5C) return {2'b00, m_on, m_sel, 4'hF};
    if (a == 8'h5D) return {m_auto, m_auto & lock_in, (m_auto ? track_in : m_shadow), m_aux, 4'h0};
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {m_on, m_sel, m_auto, m_aux, m_shadow, m_trk} = '0;
      m_rd = 8'h00;
    end else begin
      bit old_on, old_sel, old_auto;
      old_on = m_on; old_sel = m_sel; old_auto = m_auto;
      m_rd = model_view(addr);
      if (wr_en && addr == 8'h5C) begin
        if (wr_data[5] || !old_sel) m_on = wr_data[5];
        if (!wr_data[4]) m_sel = 0;
        else if (old_on && m_on) m_sel = 1;
      end
      if (wr_en && addr == 8'h5D) begin
        m_auto = wr_data[7];
        m_aux  = wr_data[4];
        if (!old_auto) m_shadow = wr_data[5];
      end
      m_trk = m_auto ? track_in : m_shadow;
    end
  end

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check("rd_data", rd_data, m_rd);
      check("loop_on_o", {7'd0, loop_on_o}, {7'd0, m_on});
      check("vco_sel_o", {7'd0, vco_sel_o}, {7'd0, m_sel});
      check("track_ctl_o", {7'd0, track_ctl_o}, {7'd0, m_trk});
    end
  end

  task automatic cyc(input bit [7:0] a, input bit w, input bit [7:0] d);
    @(negedge clk); #1;
    addr = a; wr_en = w; wr_data = d;
  endtask

  task automatic wr(input bit [7:0] a, input bit [7:0] d);
    cyc(a, 1'b1, d);
    cyc(a, 1'b0, 8'h00);
    cyc(a, 1'b0, 8'h00);
  endtask

  task automatic rd(input bit [7:0] a);
    cyc(a, 1'b0, 8'h00);
    cyc(a, 1'b0, 8'h00);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit [15:0] lfsr;
    cur_req = "R1";
    repeat (3) cyc(8'h5C, 1'b0, 8'h00);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    check("R1 reset outputs", {5'd0, loop_on_o, vco_sel_o, track_ctl_o}, 8'h00);
    rd(8'h5C); rd(8'h5D);

    cur_req = "R3";
    wr(8'h5C, 8'hCF);          // only ignored bits set
    rd(8'h5C);
    cur_req = "R5";
    wr(8'h5C, 8'hFF);          // both from off: on sets, sel stays 0
    @(negedge clk);
    check("R5 dual set sel", {7'd0, vco_sel_o}, 8'h00);
    wr(8'h5C, 8'h30);          // sel now allowed
    cur_req = "R4";
    wr(8'h5C, 8'h10);          // clear on blocked
    @(negedge clk);
    check("R4 on held", {7'd0, loop_on_o}, 8'h01);
    wr(8'h5C, 8'h00);          // sel cleared, on blocked (pre sel=1)
    wr(8'h5C, 8'h00);          // on cleared
    cur_req = "R5";
    wr(8'h5C, 8'h10);          // sel blocked while off
    wr(8'h5C, 8'h20);
    wr(8'h5C, 8'h10);          // clear on and set sel together
    @(negedge clk);
    check("R5 clear+set", {6'd0, loop_on_o, vco_sel_o}, 8'h00);

    cur_req = "R6";
    wr(8'h5D, 8'h1F);
    rd(8'h5D);
    cur_req = "R8";
    lock_in = 1'b1; track_in = 1'b0;
    wr(8'h5D, 8'h20);          // manual tracking
    @(negedge clk);
    check("R8 manual track", {7'd0, track_ctl_o}, 8'h01);
    wr(8'h5D, 8'h00);
    cur_req = "R7";
    wr(8'h5D, 8'hA0);          // to auto; trk written since pre-write manual
    for (int i = 0; i < 8; i++) begin
      lock_in = i[0]; track_in = i[1];
      cyc(8'h5D, 1'b0, 8'h00);
    end
    cur_req = "R8";
    track_in = 1'b0;
    wr(8'h5D, 8'h80);          // trk write ignored in auto
    cur_req = "R9";
    wr(8'h5D, 8'h00);          // back to manual: shadow 1 restored
    @(negedge clk);
    check("R9 shadow restore", {7'd0, track_ctl_o}, 8'h01);
    rd(8'h5D);

    cur_req = "R2";
    rd(8'h00); rd(8'hFF); rd(8'h5E); rd(8'h5B);

    cur_req = "R9";
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      bit [7:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0: a = 8'h5C;
        2'd1: a = 8'h5D;
        2'd2: a = 8'h5D;
        default: a = lfsr[15:8];
      endcase
      lock_in = lfsr[4]; track_in = lfsr[6];
      cyc(a, lfsr[2] & lfsr[3], lfsr[15:8] ^ lfsr[7:0]);
    end
    cyc(8'h00, 1'b0, 8'h00);
    @(negedge clk);
    finish_run();
  end
endmodule